// File: doc/BRIEF.md
# Half-Bridge Dead-Time Drive Sequencer

This block turns a fixed-frequency oscillator tick and a digital on-time command into four gate-enable levels for an isolated half-bridge converter. Two enables go to the primary switches (low side and high side), which take turns: one pulse per oscillator period, alternating sides. The other two go to the secondary synchronous rectifiers through a pulse transformer. Each rectifier enable is active high. When both are high, both rectifiers conduct, which is the freewheel state.

Each period starts at a tick. If a pulse is due, the rectifier that belongs to the chosen side turns off first. The primary then turns on after a programmable lead delay and stays on for the on-time. The on-time is the smaller of the duty command and the soft-start limit. After the primary turns off, the rectifier turns back on after a programmable trailing delay. The block measures the length of the period from the spacing of the ticks. It caps the on-time so the primary is off half a dead time before the next boundary. If the trailing delay would cross that boundary, the rectifier is forced back on at the tick. All delays and on-times are counted in system clock cycles.

Top module: `hb_deadtime_seq`

## Requirements
- R1: While reset or the enable is low, both primary enables are low and both rectifier enables are high.
- R2: Primary pulses alternate between low side and high side, at most one per period and never both at once. The first pulse after the enable rises is always low side.
- R3: A primary enable rises exactly L cycles after its rectifier enable falls, with L = lead_dly, or 1 when lead_dly is 0.
- R4: The pulse width equals min(duty_cmd, ss_limit) clock cycles, unless R7 or R8 changes it.
- R5: A rectifier enable rises exactly T cycles after its primary enable falls, with T = trail_dly, or 1 when trail_dly is 0, unless R6 applies.
- R6: If the trailing delay would end after the next tick, the rectifier stays off to the end of the period and is high in the first cycle after that tick.
- R7: A non-zero on-time command below MIN_ON cycles is raised to MIN_ON. A pulse shorter than MIN_ON is never issued.
- R8: The on-time is capped at P - floor(P*35/1024) - L. P is the spacing in cycles of the two ticks that open the period.
- R9: A low enable clears both primary enables from the next sampled cycle on, with no clock edge needed. Both rectifiers return to on, and the next pulse is low side.
- R10: A zero on-time command issues no pulse, leaves both rectifiers on, and does not advance the alternation.
- R11: Delays and on-time are captured at the tick. Input changes within a period take effect from the next period.
- R12: No primary enable is high while its rectifier enable is high or changing. Both rectifiers are on only while no primary is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Switching enable |
| osc_tick | input | 1 | One-cycle pulse marking the start of each oscillator period |
| duty_cmd | input | CW | Commanded primary on-time in cycles |
| ss_limit | input | CW | Soft-start ceiling on the on-time in cycles |
| lead_dly | input | BW | Delay from rectifier off to primary on |
| trail_dly | input | BW | Delay from primary off to rectifier on |
| pri_lo | output | 1 | Low-side primary gate enable |
| pri_hi | output | 1 | High-side primary gate enable |
| sr_lo | output | 1 | Rectifier enable related to the low side |
| sr_hi | output | 1 | Rectifier enable related to the high side |

## Verification
The bound checker watches every cycle for these properties:
- each side's interlock between its primary and rectifier;
- the two primaries never being on together;
- a rectifier having been off for a cycle before its primary rises;
- the minimum pulse width;
- the idle output state while the enable is low.

Other behaviour depends on the exact numbers, and only the bench's directed scenarios can show it:
- exact lead and trailing delays, including a zero delay;
- soft-start and minimum-width on-times;
- the period-based on-time cap and the clipped trailing edge;
- sampling of inputs at the period start;
- the low-side restart after a disable.

// File: rtl/hb_deadtime_seq.sv
module hb_deadtime_seq #(
  parameter int CW       = 12,
  parameter int BW       = 8,
  parameter int MIN_ON   = 20,
  parameter int HD_NUM   = 35,
  parameter int HD_SHIFT = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          osc_tick,
  input  logic [CW-1:0] duty_cmd,
  input  logic [CW-1:0] ss_limit,
  input  logic [BW-1:0] lead_dly,
  input  logic [BW-1:0] trail_dly,
  output logic          pri_lo,
  output logic          pri_hi,
  output logic          sr_lo,
  output logic          sr_hi
);
  localparam int SW = CW + 1;
  localparam int PW = CW + $clog2(HD_NUM + 1);
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] MINV = CW'(MIN_ON);
  localparam logic [CW-1:0] CMAX = '1 - ONE;
  localparam logic [PW-1:0] HDN  = PW'(HD_NUM);

  logic [CW-1:0] cnt_q, lead_q, trail_q, ton_q;
  logic          seen_q, go_q, pon_q, side_q, nxt_q, srl_q, srh_q;

  logic [CW-1:0] meas, hd, lead_e, trail_e, room, req, req_m, ton;
  logic [PW-1:0] prod;
  logic [SW-1:0] need, nxt_cnt, t_on, t_off, t_sr;
  logic          valid;

  assign meas    = seen_q ? cnt_q + ONE : '0;
  assign prod    = PW'(meas) * HDN;
  assign hd      = CW'(prod >> HD_SHIFT);
  assign lead_e  = (lead_dly == '0) ? ONE : CW'(lead_dly);
  assign trail_e = (trail_dly == '0) ? ONE : CW'(trail_dly);
  assign need    = {1'b0, hd} + {1'b0, lead_e};
  assign room    = ({1'b0, meas} > need) ? meas - need[CW-1:0] : '0;
  assign req     = (duty_cmd < ss_limit) ? duty_cmd : ss_limit;
  assign req_m   = (req != '0 && req < MINV) ? MINV : req;
  assign ton     = (req_m < room) ? req_m : room;
  assign valid   = (ton >= MINV);

  assign nxt_cnt = {1'b0, cnt_q} + SW'(1);
  assign t_on    = {1'b0, lead_q};
  assign t_off   = t_on + {1'b0, ton_q};
  assign t_sr    = t_off + {1'b0, trail_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      seen_q  <= 1'b0;
      go_q    <= 1'b0;
      pon_q   <= 1'b0;
      side_q  <= 1'b0;
      nxt_q   <= 1'b0;
      srl_q   <= 1'b1;
      srh_q   <= 1'b1;
      lead_q  <= ONE;
      trail_q <= ONE;
      ton_q   <= '0;
    end else begin
      cnt_q  <= osc_tick ? '0 : ((cnt_q == CMAX) ? cnt_q : cnt_q + ONE);
      seen_q <= seen_q | osc_tick;
      if (!en) begin
        go_q  <= 1'b0;
        pon_q <= 1'b0;
        srl_q <= 1'b1;
        srh_q <= 1'b1;
        nxt_q <= 1'b0;
      end else if (osc_tick) begin
        pon_q   <= 1'b0;
        go_q    <= valid;
        side_q  <= nxt_q;
        lead_q  <= lead_e;
        trail_q <= trail_e;
        ton_q   <= ton;
        srl_q   <= !(valid && !nxt_q);
        srh_q   <= !(valid && nxt_q);
        if (valid) nxt_q <= ~nxt_q;
      end else if (go_q) begin
        if (nxt_cnt == t_on)  pon_q <= 1'b1;
        if (nxt_cnt == t_off) pon_q <= 1'b0;
        if (nxt_cnt == t_sr) begin
          srl_q <= 1'b1;
          srh_q <= 1'b1;
          go_q  <= 1'b0;
        end
      end
    end
  end

  assign pri_lo = en & pon_q & ~side_q;
  assign pri_hi = en & pon_q & side_q;
  assign sr_lo  = ~en | srl_q;
  assign sr_hi  = ~en | srh_q;
endmodule

// File: rtl/hb_deadtime_seq_chk.sv
module hb_deadtime_seq_chk #(
  parameter int MIN_ON = 20
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic pri_lo,
  input logic pri_hi,
  input logic sr_lo,
  input logic sr_hi
);
  logic        pri_any;
  logic [15:0] on_len;

  assign pri_any = pri_lo | pri_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) on_len <= '0;
    else if (pri_any) on_len <= (on_len == 16'hffff) ? on_len : on_len + 16'd1;
    else on_len <= '0;
  end

  a_r12_lo_interlock: assert property (@(posedge clk) disable iff (!rst_n)
    pri_lo |-> !sr_lo);
  a_r12_hi_interlock: assert property (@(posedge clk) disable iff (!rst_n)
    pri_hi |-> !sr_hi);
  a_r12_freewheel: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_lo && sr_hi) |-> !pri_any);
  a_r2_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    !(pri_lo && pri_hi));
  a_r3_lo_lead: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pri_lo) |-> $past(!sr_lo));
  a_r3_hi_lead: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pri_hi) |-> $past(!sr_hi));
  a_r7_min_width: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $fell(pri_any)) |-> (on_len >= 16'(MIN_ON)));
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!pri_any && sr_lo && sr_hi));
endmodule

bind hb_deadtime_seq hb_deadtime_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en),
  .pri_lo(pri_lo), .pri_hi(pri_hi), .sr_lo(sr_lo), .sr_hi(sr_hi)
);

// File: tb/test_hb_deadtime_seq.sv
`timescale 1ns/1ps
module test_hb_deadtime_seq;
  logic clk = 0, rst_n = 0, en = 0, osc_tick = 0;
  logic [11:0] duty = 0, ss = 12'hfff;
  logic [7:0]  lead = 10, trail = 8;
  logic pri_lo, pri_hi, sr_lo, sr_hi;

  int n_chk = 0, n_err = 0, viol = 0, exp_nxt = 0;
  int g_lo, g_hi, g_rise, g_fall, g_lof, g_lor, g_hif, g_hir, g_kbad;
  logic g_lo1, g_hi1, g_loE, g_hiE, p_lo = 1, p_hi = 1;
  logic [7:0] chg_lead;
  logic [11:0] chg_duty;

  always #2.5 clk = ~clk;

  hb_deadtime_seq i_hb_deadtime_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .osc_tick(osc_tick),
    .duty_cmd(duty), .ss_limit(ss), .lead_dly(lead), .trail_dly(trail),
    .pri_lo(pri_lo), .pri_hi(pri_hi), .sr_lo(sr_lo), .sr_hi(sr_hi)
  );

  // R12: per-cycle window monitor
  always @(negedge clk) if (rst_n) begin
    if ((pri_lo && (sr_lo || sr_lo != p_lo)) || (pri_hi && (sr_hi || sr_hi != p_hi)) ||
        (sr_lo && sr_hi && (pri_lo || pri_hi))) viol++;
    p_lo = sr_lo;
    p_hi = sr_hi;
  end

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic period(input int P, input int kill_at, input int chg_at);
    g_lo = 0; g_hi = 0; g_rise = -1; g_fall = -1; g_kbad = 0;
    g_lof = -1; g_lor = -1; g_hif = -1; g_hir = -1;
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      if (pri_lo) g_lo++;
      if (pri_hi) g_hi++;
      if ((pri_lo || pri_hi) && g_rise < 0) g_rise = i;
      if (!pri_lo && !pri_hi && g_rise >= 0 && g_fall < 0) g_fall = i;
      if (!sr_lo && g_lof < 0) g_lof = i;
      if (sr_lo && g_lof >= 0 && g_lor < 0) g_lor = i;
      if (!sr_hi && g_hif < 0) g_hif = i;
      if (sr_hi && g_hif >= 0 && g_hir < 0) g_hir = i;
      if (i == 1) begin g_lo1 = sr_lo; g_hi1 = sr_hi; end
      if (kill_at >= 0 && i > kill_at && (pri_lo || pri_hi || !sr_lo || !sr_hi)) g_kbad++;
      if (i == kill_at) en = 0;
      if (i == chg_at) begin lead = chg_lead; duty = chg_duty; end
      osc_tick = (i == 0);
    end
    g_loE = sr_lo;
    g_hiE = sr_hi;
  endtask

  task automatic pulse_chk(input int el, input int ew, input int et);
    int side = (g_lo > 0) ? 0 : ((g_hi > 0) ? 1 : -1);
    chk("R2 side", side, exp_nxt);
    chk("R2 single side", (g_lo > 0 && g_hi > 0) ? 1 : 0, 0);
    chk("R4 width", g_lo + g_hi, ew);
    chk("R3 lead", g_rise - (side == 1 ? g_hif : g_lof), el);
    if (et >= 0) chk("R5 trail", (side == 1 ? g_hir : g_lor) - g_fall, et);
    exp_nxt ^= 1;
  endtask

  task automatic t_reset;
    chk("R1 pri_lo", pri_lo, 0);
    chk("R1 pri_hi", pri_hi, 0);
    chk("R1 sr_lo", sr_lo, 1);
    chk("R1 sr_hi", sr_hi, 1);
    period(200, -1, -1);
    chk("R1 idle no switching", g_lof + g_hif, -2);
  endtask

  task automatic t_basic;
    en = 1; lead = 10; trail = 8; duty = 60; ss = 12'hfff;
    period(200, -1, -1); pulse_chk(10, 60, 8);
    period(200, -1, -1); pulse_chk(10, 60, 8);
    period(200, -1, -1); pulse_chk(10, 60, 8);
  endtask

  task automatic t_softstart;
    ss = 30;
    period(200, -1, -1); pulse_chk(10, 30, 8);
    ss = 12'hfff;
  endtask

  task automatic t_minon;
    duty = 5;
    period(200, -1, -1); pulse_chk(10, 20, 8);  // R7
    duty = 60;
  endtask

  task automatic t_zero_delays;
    lead = 0; trail = 0;
    period(200, -1, -1); pulse_chk(1, 60, 1);
    lead = 10; trail = 8;
  endtask

  task automatic t_zero_duty;
    duty = 0;
    period(200, -1, -1);
    chk("R10 no pulse", g_lo + g_hi, 0);
    chk("R10 rectifiers stay on", g_lof + g_hif, -2);
    duty = 60;
    period(200, -1, -1); pulse_chk(10, 60, 8);  // R10 alternation unchanged
  endtask

  task automatic t_sample;
    chg_lead = 40; chg_duty = 100;
    period(200, -1, 3); pulse_chk(10, 60, 8);   // R11 current period unaffected
    period(200, -1, -1); pulse_chk(40, 100, 8); // R11 next period uses new values
    lead = 10; duty = 60;
  endtask

  task automatic t_clip;
    int side;
    duty = 0;
    period(100, -1, -1);
    duty = 200; trail = 20;
    period(100, -1, -1);
    side = exp_nxt;
    pulse_chk(10, 87, -1);                       // R8 cap 100-3-10
    chk("R6 no rise in period", side ? g_hir : g_lor, -1);
    chk("R6 off at period end", side ? g_hiE : g_loE, 0);
    duty = 0;
    period(100, -1, -1);
    chk("R6 on after boundary", side ? g_hi1 : g_lo1, 1);
    period(200, -1, -1);
    duty = 60; trail = 8;
  endtask

  task automatic t_disable;
    if (exp_nxt == 1) begin period(200, -1, -1); pulse_chk(10, 60, 8); end
    period(200, 30, -1);
    chk("R9 outputs idle after disable", g_kbad, 0);
    chk("R9 pulse had started", (g_rise >= 0) ? 1 : 0, 1);
    exp_nxt = 0;
    period(200, -1, -1);
    chk("R9 no pulse while disabled", g_lo + g_hi + g_lof + g_hif, -2);
    en = 1;
    period(200, -1, -1); pulse_chk(10, 60, 8);  // R9 restarts low side
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_softstart;
    t_minon;
    t_zero_delays;
    t_zero_duty;
    t_sample;
    t_clip;
    t_disable;
    chk("R12 interlock window", viol, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule